// File: doc/BRIEF.md
# SPI-Mode Card Block Read Responder

This block is the card-side sequencer that answers block read commands on a byte-wide SPI-style link. Each exchange, marked by a one-cycle `xfer_en` strobe, takes one byte from the host and loads the byte to be returned into a register. That byte can be read on `resp_byte` from the cycle after the strobe. Command decoding sits outside the block. It raises `rd_start` with the command index on `rd_cmd` once a read command has been accepted.

Once started, the responder sends the start token 0xFE. It then sends block data pulled one byte per exchange from a simple byte source, and after that a two-byte CRC16. For a multiple-block read it starts the next block with a fresh token and CRC, and it keeps doing so until the host sends the stop-transmission command byte. The stop byte is honoured in every data phase. After a stop, one extra filler exchange must pass before `cmd_ready` tells the response logic that it may answer.

Top module: `sdr_rd_resp`

## Requirements
- R1: After reset, `resp_byte` is 0xFF, `cmd_ready` is 1 and `src_pop` is 0.
- R2: While in command mode, every exchange returns 0xFF and pops nothing. A host byte of 0x4C in command mode leaves `cmd_ready` at 1.
- R3: When `rd_start` is high while `cmd_ready` is 1, the block latches `rd_cmd` and drops `cmd_ready`. Its next exchange returns the start token 0xFE and pops nothing.
- R4: After the token, each exchange returns `src_data` and pulses `src_pop` during that exchange, so bytes go out in source order. A block ends after 512 data bytes, or earlier after a byte taken while `src_more` is 0.
- R5: After the data, the next two exchanges return the CRC16 of that block's data bytes, most significant byte first. The CRC uses polynomial 0x1021, starts from 0x0000 at every block and does not reflect bits.
- R6: After the second CRC byte, the block starts the next block with a token if the block held 512 bytes and the latched command is not 17. Otherwise it returns to command mode with `cmd_ready` at 1.
- R7: A host byte of 0x4C in any exchange from token through the second CRC byte ends the read at once. That exchange returns 0xFF and pops nothing.
- R8: After a stop, `cmd_ready` stays 0 until one further exchange has returned 0xFF. After that exchange it is 1.
- R9: `rd_start` has no effect while `cmd_ready` is 0, so a read in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_en | input | 1 | One exchange occurs in this cycle |
| host_byte | input | 8 | Byte received from the host in this exchange |
| resp_byte | output | 8 | Byte returned by the most recent exchange |
| rd_start | input | 1 | Pulse: a read command was accepted |
| rd_cmd | input | 6 | Command index that goes with `rd_start` |
| cmd_ready | output | 1 | Command mode, with no stop delay pending |
| src_data | input | 8 | Current byte from the data source |
| src_more | input | 1 | Source has more bytes after `src_data` |
| src_pop | output | 1 | Current source byte is consumed in this exchange |

## Verification
Single-block reads are run with a full 512-byte source and with a 10-byte source. The first shows that command 17 stops after one full block, and the second shows that an exhausted source cuts a block short. Multiple-block reads are run with 1029 and with 1024 source bytes. The first shows a full block chaining into the next one against a short final block that returns to command mode. The second leaves the block waiting at a token when the stop arrives. Stop bytes are sent at the token, mid-data and between the CRC bytes, and a read that follows is then checked to confirm that the CRC was reset. A start pulse given mid-read, with a single-block command, must not stop the chaining.

// File: rtl/sdr_pkg.sv
package sdr_pkg;
  typedef enum logic [1:0] {
    PH_CMD  = 2'd0,
    PH_PREP = 2'd1,
    PH_DATA = 2'd2,
    PH_CRC  = 2'd3
  } phase_t;

  // CRC16, polynomial 0x1021, MSB first, one byte per call
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    r = c ^ {b, 8'h00};
    for (int i = 0; i < 8; i++) begin
      r = r[15] ? ((r << 1) ^ 16'h1021) : (r << 1);
    end
    return r;
  endfunction
endpackage

// File: rtl/sdr_rst_sync.sv
module sdr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/sdr_crc_acc.sv
module sdr_crc_acc
  import sdr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);
  logic [15:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)     crc_d = 16'h0000;
    else if (en) crc_d = crc16_step(crc_q, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= 16'h0000;
    else        crc_q <= crc_d;
  end

  assign crc = crc_q;
endmodule

// File: rtl/sdr_blk_cnt.sv
module sdr_blk_cnt #(
  parameter int BLK_LEN = 512,
  localparam int CNT_W = $clog2(BLK_LEN + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic last,
  output logic full
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign last = (cnt_q == CNT_W'(BLK_LEN - 1));
  assign full = (cnt_q == CNT_W'(BLK_LEN));
endmodule

// File: rtl/sdr_rd_fsm.sv
module sdr_rd_fsm
  import sdr_pkg::*;
#(
  parameter logic [5:0] SINGLE_CMD = 6'd17,
  parameter logic [7:0] STOP_BYTE  = 8'h4C,
  parameter logic [7:0] TOKEN_BYTE = 8'hFE,
  parameter logic [7:0] FILL_BYTE  = 8'hFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_en,
  input  logic [7:0]  host_byte,
  input  logic        rd_start,
  input  logic [5:0]  rd_cmd,
  input  logic [7:0]  src_data,
  input  logic        src_more,
  input  logic        blk_last,
  input  logic        blk_full,
  input  logic [15:0] crc,
  output logic        cnt_clr,
  output logic        cnt_inc,
  output logic        crc_clr,
  output logic        crc_en,
  output logic        src_pop,
  output logic [7:0]  resp_byte,
  output logic        cmd_ready,
  output phase_t      phase
);
  phase_t     phase_q, phase_d;
  logic       stop_q, stop_d;
  logic       pos_q, pos_d;
  logic [5:0] cmd_q, cmd_d;
  logic [7:0] resp_q, resp_d;
  logic       stop_hit;

  assign stop_hit = xfer_en && (phase_q != PH_CMD) && (host_byte == STOP_BYTE);

  always_comb begin
    phase_d = phase_q;
    stop_d  = stop_q;
    pos_d   = pos_q;
    cmd_d   = cmd_q;
    resp_d  = resp_q;
    cnt_clr = 1'b0;
    cnt_inc = 1'b0;
    crc_clr = 1'b0;
    crc_en  = 1'b0;
    src_pop = 1'b0;
    if (stop_hit) begin
      phase_d = PH_CMD;
      stop_d  = 1'b1;
      pos_d   = 1'b0;
      resp_d  = FILL_BYTE;
      cnt_clr = 1'b1;
    end else if (xfer_en) begin
      unique case (phase_q)
        PH_CMD: begin
          resp_d = FILL_BYTE;
          stop_d = 1'b0;
        end
        PH_PREP: begin
          resp_d  = TOKEN_BYTE;
          phase_d = PH_DATA;
          cnt_clr = 1'b1;
          crc_clr = 1'b1;
        end
        PH_DATA: begin
          resp_d  = src_data;
          src_pop = 1'b1;
          cnt_inc = 1'b1;
          crc_en  = 1'b1;
          if (!src_more || blk_last) phase_d = PH_CRC;
        end
        PH_CRC: begin
          resp_d = pos_q ? crc[7:0] : crc[15:8];
          if (pos_q) begin
            pos_d   = 1'b0;
            cnt_clr = 1'b1;
            phase_d = (blk_full && cmd_q != SINGLE_CMD) ? PH_PREP : PH_CMD;
          end else begin
            pos_d = 1'b1;
          end
        end
        default: phase_d = PH_CMD;
      endcase
    end else if (rd_start && phase_q == PH_CMD && !stop_q) begin
      phase_d = PH_PREP;
      cmd_d   = rd_cmd;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      stop_q  <= 1'b0;
      pos_q   <= 1'b0;
      cmd_q   <= 6'd0;
      resp_q  <= FILL_BYTE;
    end else begin
      phase_q <= phase_d;
      stop_q  <= stop_d;
      pos_q   <= pos_d;
      cmd_q   <= cmd_d;
      resp_q  <= resp_d;
    end
  end

  assign resp_byte = resp_q;
  assign cmd_ready = (phase_q == PH_CMD) && !stop_q;
  assign phase     = phase_q;
endmodule

// File: rtl/sdr_rd_resp.sv
module sdr_rd_resp
  import sdr_pkg::*;
#(
  parameter int         BLK_LEN    = 512,
  parameter logic [5:0] SINGLE_CMD = 6'd17,
  parameter logic [7:0] STOP_BYTE  = 8'h4C,
  parameter logic [7:0] TOKEN_BYTE = 8'hFE,
  parameter logic [7:0] FILL_BYTE  = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer_en,
  input  logic [7:0] host_byte,
  output logic [7:0] resp_byte,
  input  logic       rd_start,
  input  logic [5:0] rd_cmd,
  output logic       cmd_ready,
  input  logic [7:0] src_data,
  input  logic       src_more,
  output logic       src_pop
);
  logic        rst_int_n;
  logic        cnt_clr, cnt_inc, crc_clr, crc_en;
  logic        blk_last, blk_full;
  logic [15:0] crc;
  phase_t      phase;

  sdr_rst_sync u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_int_n)
  );

  sdr_blk_cnt #(.BLK_LEN(BLK_LEN)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .clr(cnt_clr), .inc(cnt_inc),
    .last(blk_last), .full(blk_full)
  );

  sdr_crc_acc u_crc (
    .clk(clk), .rst_n(rst_int_n), .clr(crc_clr), .en(crc_en),
    .din(src_data), .crc(crc)
  );

  sdr_rd_fsm #(
    .SINGLE_CMD(SINGLE_CMD), .STOP_BYTE(STOP_BYTE),
    .TOKEN_BYTE(TOKEN_BYTE), .FILL_BYTE(FILL_BYTE)
  ) u_fsm (
    .clk(clk), .rst_n(rst_int_n), .xfer_en(xfer_en), .host_byte(host_byte),
    .rd_start(rd_start), .rd_cmd(rd_cmd), .src_data(src_data),
    .src_more(src_more), .blk_last(blk_last), .blk_full(blk_full),
    .crc(crc), .cnt_clr(cnt_clr), .cnt_inc(cnt_inc), .crc_clr(crc_clr),
    .crc_en(crc_en), .src_pop(src_pop), .resp_byte(resp_byte),
    .cmd_ready(cmd_ready), .phase(phase)
  );
endmodule

// File: rtl/sdr_rd_chk.sv
module sdr_rd_chk
  import sdr_pkg::*;
#(
  parameter logic [7:0] STOP_BYTE  = 8'h4C,
  parameter logic [7:0] TOKEN_BYTE = 8'hFE,
  parameter logic [7:0] FILL_BYTE  = 8'hFF
) (
  input logic       clk,
  input logic       rst_n,
  input logic       xfer_en,
  input logic [7:0] host_byte,
  input logic       rd_start,
  input logic [7:0] resp_byte,
  input logic       cmd_ready,
  input logic       src_pop,
  input phase_t     phase
);
  // R2
  idle_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && cmd_ready) |=> (resp_byte == FILL_BYTE && cmd_ready));

  // R3
  token_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && phase == PH_PREP && host_byte != STOP_BYTE) |=> (resp_byte == TOKEN_BYTE));

  // R4
  pop_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    src_pop |-> (xfer_en && phase == PH_DATA));

  // R7
  stop_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && phase != PH_CMD && host_byte == STOP_BYTE)
      |=> (phase == PH_CMD && !cmd_ready && resp_byte == FILL_BYTE));

  // R8
  stop_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_en && phase == PH_CMD && !cmd_ready) |=> cmd_ready);

  // R9
  start_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_start && !cmd_ready && !xfer_en) |=> $stable(phase));
endmodule

bind sdr_rd_resp sdr_rd_chk #(
  .STOP_BYTE(STOP_BYTE), .TOKEN_BYTE(TOKEN_BYTE), .FILL_BYTE(FILL_BYTE)
) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .host_byte(host_byte),
  .rd_start(rd_start), .resp_byte(resp_byte), .cmd_ready(cmd_ready),
  .src_pop(src_pop), .phase(phase)
);

// File: tb/tb_sdr_rd_resp.sv
module tb_sdr_rd_resp;
  logic       clk;
  logic       rst_n;
  logic       xfer_en;
  logic [7:0] host_byte;
  logic [7:0] resp_byte;
  logic       rd_start;
  logic [5:0] rd_cmd;
  logic       cmd_ready;
  logic [7:0] src_data;
  logic       src_more;
  logic       src_pop;

  int src_idx;
  int src_len;
  int src_seed;
  int total;
  int bad;
  logic [15:0] tb_crc;
  logic [7:0]  exp_q[$];
  string       tag_q[$];
  event        got_byte;

  sdr_rd_resp dut (
    .clk(clk), .rst_n(rst_n), .xfer_en(xfer_en), .host_byte(host_byte),
    .resp_byte(resp_byte), .rd_start(rd_start), .rd_cmd(rd_cmd),
    .cmd_ready(cmd_ready), .src_data(src_data), .src_more(src_more),
    .src_pop(src_pop)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] src_byte(input int i, input int s);
    return 8'((i * 7 + s * 13 + (i >> 3)) & 255);
  endfunction

  assign src_data = src_byte(src_idx, src_seed);
  assign src_more = (src_idx + 1 < src_len);

  // Bitwise reference CRC: feedback from top bit xor data bit
  function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] b);
    logic [15:0] r;
    logic fb;
    r = c;
    for (int k = 7; k >= 0; k--) begin
      fb = r[15] ^ b[k];
      r  = {r[14:0], 1'b0};
      if (fb) r = r ^ 16'h1021;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard each time an exchange result is ready
  initial begin
    forever begin
      @(got_byte);
      if (exp_q.size() == 0) begin
        check(1'b0, "scoreboard-empty", resp_byte, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(resp_byte == e, t, resp_byte, e);
      end
    end
  end

  // Driver: one exchange; expected result goes onto the scoreboard
  task automatic xfer(input logic [7:0] h, input logic [7:0] exp, input bit exp_pop,
                      input string tag);
    logic popped;
    @(negedge clk);
    host_byte = h;
    xfer_en   = 1'b1;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    #2;
    popped = src_pop;
    check(popped == exp_pop, {tag, " pop"}, popped, exp_pop);
    @(posedge clk);
    #1;
    xfer_en = 1'b0;
    if (popped) src_idx++;
    -> got_byte;
  endtask

  task automatic src_setup(input int len, input int seed);
    src_idx  = 0;
    src_len  = len;
    src_seed = seed;
  endtask

  task automatic start_rd(input logic [5:0] c);
    @(negedge clk);
    rd_cmd   = c;
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    check(cmd_ready == 1'b0, "R3 cmd_ready drop", cmd_ready, 0);
  endtask

  task automatic send_token();
    xfer(8'hFF, 8'hFE, 1'b0, "R3 token");
    tb_crc = 16'h0000;
  endtask

  task automatic send_data(input int n);
    for (int k = 0; k < n; k++) begin
      logic [7:0] d;
      d = src_byte(src_idx, src_seed);
      tb_crc = ref_crc(tb_crc, d);
      xfer(8'hFF, d, 1'b1, "R4 data");
    end
  endtask

  task automatic send_crc();
    xfer(8'hFF, tb_crc[15:8], 1'b0, "R5 crc hi");
    xfer(8'hFF, tb_crc[7:0], 1'b0, "R5 crc lo");
  endtask

  task automatic read_block(input int n);
    send_token();
    send_data(n);
    send_crc();
  endtask

  task automatic stop_and_wait();
    xfer(8'h4C, 8'hFF, 1'b0, "R7 stop");
    @(negedge clk);
    check(cmd_ready == 1'b0, "R8 busy after stop", cmd_ready, 0);
    xfer(8'hFF, 8'hFF, 1'b0, "R8 filler");
    @(negedge clk);
    check(cmd_ready == 1'b1, "R8 ready after filler", cmd_ready, 1);
  endtask

  initial begin
    #1500000;
    check(1'b0, "watchdog", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    total = 0; bad = 0;
    rst_n = 1'b0; xfer_en = 1'b0; host_byte = 8'h00;
    rd_start = 1'b0; rd_cmd = 6'd0;
    tb_crc = 16'h0;
    src_setup(0, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1
    check(resp_byte == 8'hFF, "R1 resp", resp_byte, 8'hFF);
    check(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
    check(src_pop == 1'b0, "R1 pop", src_pop, 0);

    // R2: command mode, including a stop byte outside any read
    src_setup(8, 1);
    xfer(8'h00, 8'hFF, 1'b0, "R2 idle");
    xfer(8'h4C, 8'hFF, 1'b0, "R2 stop in cmd");
    @(negedge clk);
    check(cmd_ready == 1'b1, "R2 ready kept", cmd_ready, 1);

    // Single block, full length, command 17 (R6)
    src_setup(600, 3);
    start_rd(6'd17);
    read_block(512);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R6 single full ends", cmd_ready, 1);
    xfer(8'hFF, 8'hFF, 1'b0, "R6 back in cmd");

    // Single block cut short by the source (R4)
    src_setup(10, 91);
    start_rd(6'd17);
    read_block(10);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R4 short ends", cmd_ready, 1);
    check(src_idx == 10, "R4 pop count", src_idx, 10);

    // Multiple blocks, short final block (R6)
    src_setup(1029, 5);
    start_rd(6'd18);
    read_block(512);
    read_block(512);
    read_block(5);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R6 multi short tail ends", cmd_ready, 1);

    // Multiple blocks, exact length, start pulse ignored, stop at token (R9, R7)
    src_setup(1024, 200);
    start_rd(6'd18);
    send_token();
    send_data(3);
    @(negedge clk);
    rd_cmd   = 6'd17;
    rd_start = 1'b1;
    @(negedge clk);
    rd_start = 1'b0;
    check(cmd_ready == 1'b0, "R9 start ignored", cmd_ready, 0);
    send_data(509);
    send_crc();
    read_block(512);
    @(negedge clk);
    check(cmd_ready == 1'b0, "R6 waits for next block", cmd_ready, 0);
    stop_and_wait();
    check(src_idx == 1024, "R7 pops at token stop", src_idx, 1024);

    // Stop in the middle of data (R7)
    src_setup(2000, 77);
    start_rd(6'd18);
    send_token();
    send_data(5);
    stop_and_wait();
    check(src_idx == 5, "R7 no pop on stop", src_idx, 5);

    // Stop between CRC bytes, then a fresh read checks CRC restart (R7, R5)
    src_setup(3, 33);
    start_rd(6'd18);
    send_token();
    send_data(3);
    xfer(8'hFF, tb_crc[15:8], 1'b0, "R5 crc hi");
    stop_and_wait();
    src_setup(4, 150);
    start_rd(6'd17);
    read_block(4);
    @(negedge clk);
    check(cmd_ready == 1'b1, "R5 read after stop ends", cmd_ready, 1);
    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule